// File: doc/BRIEF.md
# Phase Shift Step Controller

This block sits between a user that wants to nudge a clock phase and a variable phase shifter that moves only by single steps through an enable/done handshake. Each user request asks for one step up or one step down. The block turns an accepted request into a one-cycle enable pulse with a direction bit. It then waits for the shifter's done pulse before it sends the next step. One further request can wait in a single pending slot. A request that finds the slot full is rejected.

The shifter reports no position of its own. It saturates at its ends and locks up once it flags overflow. The controller therefore keeps the position count itself and refuses any step that would carry the committed target beyond 0 or the top code. It raises level flags when the position sits at either end. When overflow is reported, it drives the shifter's reset for a programmed number of cycles and reloads its count with a programmed start value. A fixed-shift mode keeps the step outputs low and turns requests away.

Top module: `ps_step_ctrl`

## Requirements
- R1: After reset `pos` equals START_POS. `ps_en`, `ps_inc`, `ps_rst`, `busy`, `req_rej` and `lim_hit` are all 0.
- R2: A request sampled at a clock edge with no step in flight and no block in force produces `ps_en`=1 for exactly the following cycle. In that cycle `ps_inc`=1 for an increment (`req_inc`=1) and 0 for a decrement.
- R3: While a step is in flight (enable sent, done not yet seen) no further `ps_en` is issued. One accepted request is held pending, with `busy`=1 from the cycle after it is taken. It is issued as `ps_en` in the cycle after the done pulse is sampled.
- R4: A request that arrives while the pending slot is full and no done is present is dropped. `req_rej` is 1 for the following cycle, and no step is ever issued for it.
- R5: On each done pulse of an outstanding step, `pos` moves by exactly one in the step's direction in the following cycle, matching the shifter's tap. It never wraps between 0 and 255.
- R6: A request that would move the committed target (position plus all accepted steps) above 255 or below 0 is refused. `lim_hit` is 1 for the following cycle and no `ps_en` is issued for it.
- R7: `at_max`=1 exactly when `pos`=255, and `at_min`=1 exactly when `pos`=0.
- R8: When `ps_ovf` is sampled high, `ps_rst` is 1 for RST_CYC consecutive cycles starting in the next cycle. `pos` reloads to START_POS and steps in flight or pending are dropped. Requests during the reset window get `req_rej`, and afterwards requests are accepted again.
- R9: While `fixed_mode`=1, `ps_en` and `ps_inc` stay 0 and every request gets `req_rej` with no change to `pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the shifter |
| rst_n | input | 1 | Active-low synchronous reset |
| fixed_mode | input | 1 | Static-offset mode: step outputs held low |
| req_valid | input | 1 | One-cycle step request |
| req_inc | input | 1 | Request direction, 1 = up, 0 = down |
| busy | output | 1 | Pending slot is occupied |
| req_rej | output | 1 | Last request dropped (slot full, reset, fixed mode) |
| lim_hit | output | 1 | Last request refused at a range end |
| ps_en | output | 1 | Step enable pulse to the shifter |
| ps_inc | output | 1 | Step direction to the shifter, valid with ps_en |
| ps_done | input | 1 | Step complete pulse from the shifter |
| ps_ovf | input | 1 | Shifter overflow, sticky until its reset |
| ps_rst | output | 1 | Reset to the shifter during recovery |
| pos | output | W | Tracked shift position |
| at_max | output | 1 | Position is at the top code |
| at_min | output | 1 | Position is zero |

## Verification
A wrong in-flight flag shows within one cycle as an enable pulse issued before a done. It also shows as a pending step that never leaves the slot, so the scoreboard waits for a done that never comes. A wrong position or target count shows in the cycle after the next done as a mismatch against the shifter model's tap. At a range end it also shows as a missing or spurious limit pulse. A wrong reset counter shows as a reset window of the wrong length, or as a reload value other than the start position at the end of recovery.

// File: rtl/ps_step_ctrl.sv
module ps_step_ctrl #(
  parameter int W         = 8,
  parameter int START_POS = 128,
  parameter int RST_CYC   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fixed_mode,
  input  logic         req_valid,
  input  logic         req_inc,
  output logic         busy,
  output logic         req_rej,
  output logic         lim_hit,
  output logic         ps_en,
  output logic         ps_inc,
  input  logic         ps_done,
  input  logic         ps_ovf,
  output logic         ps_rst,
  output logic [W-1:0] pos,
  output logic         at_max,
  output logic         at_min
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] INIT = W'(START_POS);

  logic          fly, fly_inc, pend, pend_inc, en_q, inc_q, in_rst;
  logic [W-1:0]  tgt;
  logic [CW-1:0] rcnt;

  wire dn        = ps_done && fly;
  wire fly_free  = !fly || dn;
  wire pend_full = pend && !dn;
  wire hold      = in_rst || ps_ovf || fixed_mode;
  wire blocked   = req_inc ? (tgt == TOP) : (tgt == '0);
  wire accept    = req_valid && !hold && !blocked && !pend_full;
  wire lim_now   = req_valid && !hold && blocked;
  wire rej_now   = req_valid && (hold || (!blocked && pend_full));

  assign busy   = pend;
  assign ps_en  = en_q && !fixed_mode;
  assign ps_inc = en_q && inc_q && !fixed_mode;
  assign at_max = (pos == TOP);
  assign at_min = (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fly <= 1'b0; fly_inc <= 1'b0; pend <= 1'b0; pend_inc <= 1'b0;
      en_q <= 1'b0; inc_q <= 1'b0; in_rst <= 1'b0; ps_rst <= 1'b0;
      rcnt <= '0; pos <= INIT; tgt <= INIT;
      req_rej <= 1'b0; lim_hit <= 1'b0;
    end else begin
      en_q    <= 1'b0;
      req_rej <= rej_now;
      lim_hit <= lim_now;
      if (in_rst) begin
        rcnt <= rcnt - CW'(1);
        if (rcnt == CW'(1)) begin
          in_rst <= 1'b0;
          ps_rst <= 1'b0;
        end
      end else if (ps_ovf) begin
        in_rst <= 1'b1; ps_rst <= 1'b1; rcnt <= CW'(RST_CYC);
        fly <= 1'b0; pend <= 1'b0; pos <= INIT; tgt <= INIT;
      end else begin
        if (dn) begin
          pos <= fly_inc ? pos + W'(1) : pos - W'(1);
          fly <= 1'b0;
        end
        if (fly_free && !fixed_mode && pend) begin
          en_q <= 1'b1; inc_q <= pend_inc;
          fly <= 1'b1; fly_inc <= pend_inc;
          pend <= accept;
          pend_inc <= req_inc;
        end else if (fly_free && accept) begin
          en_q <= 1'b1; inc_q <= req_inc;
          fly <= 1'b1; fly_inc <= req_inc;
        end else if (accept) begin
          pend <= 1'b1; pend_inc <= req_inc;
        end
        if (accept) tgt <= req_inc ? tgt + W'(1) : tgt - W'(1);
      end
    end
  end

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |=> !ps_en); // R2

  AST_NO_EN_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (fly && !ps_done) |=> !ps_en); // R3

  AST_POS_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rst && !ps_ovf) |=> ({1'b0, pos} == {1'b0, $past(pos)} ||
                              {1'b0, pos} == {1'b0, $past(pos)} + (W+1)'(1) ||
                              {1'b0, pos} + (W+1)'(1) == {1'b0, $past(pos)})); // R5

  AST_LIM_NO_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    lim_hit |-> !req_rej); // R6

  AST_RST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_ovf && !in_rst) |=> (ps_rst && pos == INIT && !busy)); // R8

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_mode && $past(fixed_mode) && $past(req_valid)) |-> (req_rej && !ps_en)); // R9
endmodule

// File: tb/tb_ps_step_ctrl.sv
module ps_shifter_model #(
  parameter int LAT   = 87,
  parameter int START = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       inc,
  input  logic       rst_in,
  input  logic       force_ovf,
  output logic       done,
  output logic       ovf,
  output logic [7:0] tap,
  output int         viol
);
  logic bsy, dir;
  int   cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || rst_in) begin
      bsy <= 1'b0; dir <= 1'b0; cnt <= 0; done <= 1'b0; ovf <= 1'b0;
      tap <= 8'(START);
      if (!rst_n) viol <= 0;
    end else begin
      done <= 1'b0;
      if (force_ovf) ovf <= 1'b1;
      if (en && bsy) viol <= viol + 1;
      if (en && !bsy && !ovf) begin
        bsy <= 1'b1; dir <= inc; cnt <= LAT;
      end else if (bsy) begin
        if (cnt == 1) begin
          bsy <= 1'b0; done <= 1'b1;
          if (dir) begin
            if (tap == 8'hFF) ovf <= 1'b1; else tap <= tap + 8'd1;
          end else begin
            if (tap == 8'h00) ovf <= 1'b1; else tap <= tap - 8'd1;
          end
        end else cnt <= cnt - 1;
      end
    end
  end
endmodule

module tb_ps_step_ctrl;
  localparam int START = 250;
  localparam int RCYC  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fixed_mode = 1'b0, req_valid = 1'b0, req_inc = 1'b0, force_ovf = 1'b0;
  logic busy, req_rej, lim_hit, ps_en, ps_inc, ps_done, ps_ovf, ps_rst, at_max, at_min;
  logic [7:0] pos, tap;
  int viol;

  int tests = 0, fails = 0, cyc = 0;
  int q[$];
  logic pend_exp = 1'b0;
  logic seen_done = 1'b0;

  always #10 clk = ~clk;

  ps_step_ctrl #(.W(8), .START_POS(START), .RST_CYC(RCYC)) dut (
    .clk(clk), .rst_n(rst_n), .fixed_mode(fixed_mode), .req_valid(req_valid),
    .req_inc(req_inc), .busy(busy), .req_rej(req_rej), .lim_hit(lim_hit),
    .ps_en(ps_en), .ps_inc(ps_inc), .ps_done(ps_done), .ps_ovf(ps_ovf),
    .ps_rst(ps_rst), .pos(pos), .at_max(at_max), .at_min(at_min));

  ps_shifter_model #(.LAT(87), .START(START)) shf (
    .clk(clk), .rst_n(rst_n), .en(ps_en), .inc(ps_inc), .rst_in(ps_rst),
    .force_ovf(force_ovf), .done(ps_done), .ovf(ps_ovf), .tap(tap), .viol(viol));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop expected position after each done
  always @(negedge clk) begin
    if (seen_done) begin
      if (q.size() == 0) chk("R5 unexpected done", 1, 0);
      else begin
        int e;
        e = q.pop_front();
        chk("R5 pos after done", int'(pos), e);
        chk("R5 pos vs tap", int'(pos), int'(tap));
        if (pend_exp) begin
          chk("R3 pending issued after done", int'(ps_en), 1);
          pend_exp = 1'b0;
        end
      end
    end
    seen_done = ps_done;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // driver: one request; kind 0 = accepted, 1 = pending, 2 = rejected, 3 = limit
  task automatic step(input logic inc, input int kind, input int exp_pos);
    @(negedge clk);
    req_valid = 1'b1; req_inc = inc;
    if (kind <= 1) q.push_back(exp_pos);
    @(negedge clk);
    req_valid = 1'b0;
    case (kind)
      0: begin
        chk("R2 enable pulse", int'(ps_en), 1);
        chk("R2 direction", int'(ps_inc), int'(inc));
      end
      1: begin
        chk("R3 busy when pending", int'(busy), 1);
        chk("R3 no enable in flight", int'(ps_en), 0);
        pend_exp = 1'b1;
      end
      2: begin
        chk("R4 reject", int'(req_rej), 1);
        chk("R4 no enable on reject", int'(ps_en), 0);
      end
      default: begin
        chk("R6 limit pulse", int'(lim_hit), 1);
        chk("R6 no enable at limit", int'(ps_en), 0);
      end
    endcase
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pos", int'(pos), START);
    chk("R1 ps_en", int'(ps_en), 0);
    chk("R1 ps_rst", int'(ps_rst), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 flags", int'(req_rej) + int'(lim_hit), 0);

    step(1'b1, 0, 251); wait_idle();
    step(1'b0, 0, 250); wait_idle();

    step(1'b1, 0, 251);
    step(1'b1, 1, 252);
    step(1'b1, 2, 0);
    wait_idle();
    chk("R4 dropped request left no trace", int'(pos), 252);
    chk("R3 busy cleared", int'(busy), 0);

    for (int p = 253; p <= 255; p++) begin
      step(1'b1, 0, p); wait_idle();
    end
    chk("R7 at_max", int'(at_max), 1);
    chk("R7 at_min low", int'(at_min), 0);
    step(1'b1, 3, 0);
    repeat (100) @(negedge clk);
    chk("R6 pos unchanged at top", int'(pos), 255);

    fixed_mode = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_inc = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 reject in fixed mode", int'(req_rej), 1);
    chk("R9 enable low", int'(ps_en), 0);
    repeat (100) @(negedge clk);
    chk("R9 pos unchanged", int'(pos), 255);
    chk("R9 direction low", int'(ps_inc), 0);
    fixed_mode = 1'b0;

    for (int p = 254; p >= 0; p--) begin
      step(1'b0, 0, p); wait_idle();
    end
    chk("R7 at_min", int'(at_min), 1);
    chk("R7 at_max low", int'(at_max), 0);
    step(1'b0, 3, 0);
    repeat (100) @(negedge clk);
    chk("R6 pos unchanged at bottom", int'(pos), 0);

    @(negedge clk);
    force_ovf = 1'b1;
    @(negedge clk);
    force_ovf = 1'b0;
    begin
      int n;
      n = 0;
      @(negedge clk);
      while (ps_rst && n < 50) begin
        n++;
        if (n == 2) begin
          req_valid = 1'b1; req_inc = 1'b1;
        end
        if (n == 3) begin
          req_valid = 1'b0;
          chk("R8 reject during reset", int'(req_rej), 1);
        end
        @(negedge clk);
      end
      chk("R8 reset length", n, RCYC);
    end
    chk("R8 pos reload", int'(pos), START);
    step(1'b1, 0, START + 1); wait_idle();

    chk("R3 model saw no early enable", viol, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule